// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor's instruction fetch port and a 32-bit pipelined memory-mapped read master. The fetch side offers a byte address while `fetchReady` is high. One cycle later a hit returns the stored 32-bit word with `fetchHit` set. A miss first refills the whole line from memory and then returns the requested word with `fetchHit` clear.

The store is direct-mapped. With the default parameters it has 128 lines of eight 32-bit words, 4 KB in all. The byte address splits into a tag (bits 31..12), a line index (bits 11..5) and a word offset (bits 4..2). Address bits 1..0 play no part. A refill puts the line-base read and the seven following reads on the bus on consecutive cycles. It does not wait for earlier data to return before issuing the next read. Only `memWait` holds the current request. Returned words are counted in by `memRdValid`. The line becomes valid only after its eighth word has arrived. Reset, or a one-cycle pulse on `invAll`, clears every valid bit.

Top module: `icache_dm`

## Requirements
- R1: After reset no line is valid: `fetchReady` is 1, `memRead` is 0, `fetchValid` is 0, and the first fetch to any address is a miss.
- R2: A fetch accepted on a valid line with a matching tag returns `fetchValid`=1, `fetchHit`=1 and the stored word in the cycle right after acceptance, and issues no memory read.
- R3: A miss issues exactly eight reads. The addresses are the line base (request address with bits 4..0 cleared), then base+4, base+8 and so on up to base+28, in ascending order.
- R4: With `memWait` low, the eight refill reads go out on eight consecutive cycles, whether or not earlier read data has returned.
- R5: While `memRead` is 1 and `memWait` is 1, the next cycle keeps `memRead` at 1 with `memAddr` unchanged.
- R6: The k-th `memRdValid` beat of a refill fills word k of the line. After the eighth beat the fetch completes with `fetchHit`=0 and the word at the requested offset.
- R7: After a refill, a fetch to any word of that line hits.
- R8: Two addresses with equal index (bits 11..5) but different tags evict each other. A fetch to the displaced address misses again.
- R9: A pulse on `invAll` clears every valid bit, so the next fetch to a previously cached line misses.
- R10: Address bits 1..0 are ignored. A fetch to A returns the same word as a fetch to A with bits 1..0 cleared.
- R11: From acceptance of a missing fetch until its response, `fetchReady` is 0. While `memRead` is 1, `fetchReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| invAll | input | 1 | One-cycle pulse that clears all valid bits |
| fetchReq | input | 1 | Fetch request, accepted while fetchReady is 1 |
| fetchAddr | input | 32 | Fetch byte address |
| fetchReady | output | 1 | Cache can accept a fetch this cycle |
| fetchValid | output | 1 | Response word is present this cycle |
| fetchData | output | 32 | Response instruction word |
| fetchHit | output | 1 | Response was served without a refill |
| memRead | output | 1 | Read request to memory |
| memAddr | output | 32 | Read byte address, word aligned |
| memWait | input | 1 | Memory stalls the current read request |
| memRdata | input | 32 | Returned read data |
| memRdValid | input | 1 | Returned read data is valid |

## Verification
A corrupted tag or valid bit appears on the very next fetch to that line. It shows up either as a wrong hit flag, or as eight bus reads where none were expected (or the reverse). A wrong beat counter or fill pointer stores a word in the wrong slot. That fault only appears when a later fetch to the affected word returns a value that does not match the memory model, so the bench reads several offsets of every filled line. A stalled or skipped issue counter shows on the bus right away, as a repeated or missing address within the eight-read burst.

// File: rtl/icache_pkg.sv
package icache_pkg;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic capture;   // latch the fetch address
    logic wrWord;    // store a returned beat into the line
    logic fillDone;  // mark the refilled line valid, write its tag
    logic rspHit;    // answer from the array using the live fetch address
    logic rspMiss;   // answer from the array using the latched address
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RESP = 2'd2
  } seqState_t;

endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fetchReq,
  input  logic                          lookupHit,
  input  logic                          memWait,
  input  logic                          memRdValid,
  output ctrlStrobe_t                   strobe,
  output logic                          fetchReady,
  output logic                          memRead,
  output logic [$clog2(LINE_WORDS)-1:0] issueIdx,
  output logic [$clog2(LINE_WORDS)-1:0] beatIdx
);

  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int CNT_W = OFF_W + 1;

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] issueCnt;
  logic [OFF_W-1:0] beatCnt;
  logic             lastBeat;

  assign fetchReady = (state == ST_IDLE);
  assign memRead    = (state == ST_FILL) && (issueCnt < CNT_W'(LINE_WORDS));
  assign issueIdx   = issueCnt[OFF_W-1:0];
  assign beatIdx    = beatCnt;
  assign lastBeat   = memRdValid && (beatCnt == OFF_W'(LINE_WORDS - 1));

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (fetchReq) begin
          strobe.capture = 1'b1;
          if (lookupHit) strobe.rspHit = 1'b1;
          else           stateNext     = ST_FILL;
        end
      end
      ST_FILL: begin
        if (memRdValid) strobe.wrWord = 1'b1;
        if (lastBeat) begin
          strobe.fillDone = 1'b1;
          stateNext       = ST_RESP;
        end
      end
      ST_RESP: begin
        strobe.rspMiss = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      issueCnt <= '0;
      beatCnt  <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) begin
        issueCnt <= '0;
        beatCnt  <= '0;
      end else if (state == ST_FILL) begin
        if (memRead && !memWait) issueCnt <= issueCnt + 1'b1;
        if (memRdValid)          beatCnt  <= beatCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/icache_dpath.sv
module icache_dpath
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_LINES  = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStrobe_t                   strobe,
  input  logic                          invAll,
  input  logic [ADDR_W-1:0]             fetchAddr,
  input  logic [$clog2(LINE_WORDS)-1:0] issueIdx,
  input  logic [$clog2(LINE_WORDS)-1:0] beatIdx,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          lookupHit,
  output logic [ADDR_W-1:0]             memAddr,
  output logic                          fetchValid,
  output logic [DATA_W-1:0]             fetchData,
  output logic                          fetchHit
);

  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = $clog2(LINE_WORDS);
  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W - BYTE_W;
  localparam int WORDS   = NUM_LINES * LINE_WORDS;
  localparam int PTR_W   = IDX_W + OFF_W;

  logic [NUM_LINES-1:0] validBits;
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [DATA_W-1:0]    dataMem [WORDS];

  logic [TAG_W-1:0] fTag, rTag;
  logic [IDX_W-1:0] fIdx, rIdx;
  logic [OFF_W-1:0] fOff, rOff;
  logic [BYTE_W-1:0] unusedByteBits;

  assign fTag = fetchAddr[ADDR_W-1 -: TAG_W];
  assign fIdx = fetchAddr[BYTE_W+OFF_W +: IDX_W];
  assign fOff = fetchAddr[BYTE_W +: OFF_W];
  assign unusedByteBits = fetchAddr[BYTE_W-1:0];

  assign lookupHit = validBits[fIdx] && (tagMem[fIdx] == fTag);
  assign memAddr   = {rTag, rIdx, issueIdx, {BYTE_W{1'b0}}};

  logic [PTR_W-1:0] wrPtr, hitPtr, missPtr;
  assign wrPtr   = {rIdx, beatIdx};
  assign hitPtr  = {fIdx, fOff};
  assign missPtr = {rIdx, rOff};

  always_ff @(posedge clk) begin
    if (rst) begin
      rTag <= '0;
      rIdx <= '0;
      rOff <= '0;
    end else if (strobe.capture) begin
      rTag <= fTag;
      rIdx <= fIdx;
      rOff <= fOff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validBits <= '0;
    end else begin
      if (invAll)          validBits       <= '0;
      if (strobe.fillDone) validBits[rIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillDone) tagMem[rIdx] <= rTag;
    if (strobe.wrWord)   dataMem[wrPtr] <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchValid <= 1'b0;
      fetchHit   <= 1'b0;
      fetchData  <= '0;
    end else begin
      fetchValid <= strobe.rspHit | strobe.rspMiss;
      fetchHit   <= strobe.rspHit;
      if (strobe.rspHit)       fetchData <= dataMem[hitPtr];
      else if (strobe.rspMiss) fetchData <= dataMem[missPtr];
    end
  end

endmodule

// File: rtl/icache_dm.sv
module icache_dm
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_LINES  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              invAll,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchData,
  output logic              fetchHit,
  output logic              memRead,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memWait,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRdValid
);

  localparam int OFF_W = $clog2(LINE_WORDS);

  ctrlStrobe_t      strobe;
  logic             lookupHit;
  logic [OFF_W-1:0] issueIdx, beatIdx;

  icache_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fetchReq   (fetchReq),
    .lookupHit  (lookupHit),
    .memWait    (memWait),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .fetchReady (fetchReady),
    .memRead    (memRead),
    .issueIdx   (issueIdx),
    .beatIdx    (beatIdx)
  );

  icache_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS),
    .NUM_LINES  (NUM_LINES)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .invAll     (invAll),
    .fetchAddr  (fetchAddr),
    .issueIdx   (issueIdx),
    .beatIdx    (beatIdx),
    .memRdata   (memRdata),
    .lookupHit  (lookupHit),
    .memAddr    (memAddr),
    .fetchValid (fetchValid),
    .fetchData  (fetchData),
    .fetchHit   (fetchHit)
  );

endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetchReady,
  input logic              memRead,
  input logic              memWait,
  input logic [ADDR_W-1:0] memAddr
);

  // R5: a stalled request is held unchanged
  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (memRead && memWait) |=> (memRead && $stable(memAddr)));

  // R3: an accepted read is followed either by silence or by the next word
  p_next_word_r3: assert property (@(posedge clk) disable iff (rst)
    (memRead && !memWait) |=> (!memRead || memAddr == $past(memAddr) + ADDR_W'(4)));

  // R3: refill addresses are word aligned
  p_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    memRead |-> (memAddr[1:0] == 2'b00));

  // R11: no new fetch is accepted while the refill is on the bus
  p_busy_in_fill_r11: assert property (@(posedge clk) disable iff (rst)
    memRead |-> !fetchReady);

  // R1: the bus is quiet right after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!memRead && fetchReady));

endmodule

bind icache_dm icache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetchReady (fetchReady),
  .memRead    (memRead),
  .memWait    (memWait),
  .memAddr    (memAddr)
);

// File: tb/sim_icache_dm.sv
`timescale 1ns/1ps
module sim_icache_dm;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        invAll = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady, fetchValid, fetchHit, memRead;
  logic [31:0] fetchData, memAddr;
  logic        memWait = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memRdValid = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  icache_dm u0 (
    .clk(clk), .rst(rst), .invAll(invAll),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchValid(fetchValid),
    .fetchData(fetchData), .fetchHit(fetchHit),
    .memRead(memRead), .memAddr(memAddr), .memWait(memWait),
    .memRdata(memRdata), .memRdValid(memRdValid)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit waitMode = 1'b0;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] w;
    w = a & 32'hFFFF_FFFC;
    return {w[15:0], ~w[31:16]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: pipelined, latency 3, optional stall pattern
  logic [31:0] pendAddr[$];
  int          pendDue[$];
  logic [31:0] issueLog[$];
  int          issueTotal = 0;
  int          firstIssue = 0;
  int          lastIssue  = 0;

  always @(negedge clk) begin
    if (rst) begin
      memWait    = 1'b0;
      memRdValid = 1'b0;
    end else begin
      memWait = waitMode && ((cyc % 3) != 0);
      if (memRead && !memWait) begin
        if (issueLog.size() == 0) firstIssue = cyc;
        lastIssue = cyc;
        issueLog.push_back(memAddr);
        issueTotal++;
        pendAddr.push_back(memAddr);
        pendDue.push_back(cyc + 3);
      end
      memRdValid = 1'b0;
      if (pendDue.size() > 0 && pendDue[0] <= cyc) begin
        memRdValid = 1'b1;
        memRdata   = memWord(pendAddr[0]);
        void'(pendAddr.pop_front());
        void'(pendDue.pop_front());
      end
    end
  end

  // Scoreboard
  logic [31:0] expData[$];
  bit          expHit[$];
  string       expReq[$];

  always @(negedge clk) begin
    if (!rst && fetchValid) begin
      if (expData.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 32'd1, 32'd0);
      end else begin
        chk(fetchData == expData[0], expReq[0], "data", fetchData, expData[0]);
        chk(fetchHit == expHit[0], expReq[0], "hit flag",
            {31'd0, fetchHit}, {31'd0, expHit[0]});
        void'(expData.pop_front());
        void'(expHit.pop_front());
        void'(expReq.pop_front());
      end
    end
  end

  task automatic doFetch(input logic [31:0] a, input bit hit, input string req,
                         input bit checkSpan);
    int startIssues;
    logic [31:0] base;
    do @(negedge clk); while (!fetchReady);
    issueLog.delete();
    startIssues = issueTotal;
    fetchReq  = 1'b1;
    fetchAddr = a;
    expData.push_back(memWord(a));
    expHit.push_back(hit);
    expReq.push_back(req);
    @(negedge clk);
    fetchReq = 1'b0;
    if (hit) begin
      // R2: response one cycle after acceptance
      chk(fetchValid == 1'b1, "R2", "hit latency", {31'd0, fetchValid}, 32'd1);
    end else begin
      // R11: busy after a missing fetch is accepted
      chk(fetchReady == 1'b0, "R11", "ready during refill", {31'd0, fetchReady}, 32'd0);
    end
    while (expData.size() != 0) @(negedge clk);
    chk((issueTotal - startIssues) == (hit ? 0 : 8), hit ? "R2" : "R3",
        "read count", 32'(issueTotal - startIssues), hit ? 32'd0 : 32'd8);
    if (!hit) begin
      base = a & 32'hFFFF_FFE0;
      for (int k = 0; k < 8 && k < issueLog.size(); k++)
        chk(issueLog[k] == base + 32'(4 * k), "R3", "refill address",
            issueLog[k], base + 32'(4 * k));
      if (checkSpan)
        chk((lastIssue - firstIssue) == 7, "R4", "back-to-back issue span",
            32'(lastIssue - firstIssue), 32'd7);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(fetchReady == 1'b1, "R1", "ready after reset", {31'd0, fetchReady}, 32'd1);
    chk(memRead == 1'b0, "R1", "no read after reset", {31'd0, memRead}, 32'd0);
    chk(fetchValid == 1'b0, "R1", "no response after reset", {31'd0, fetchValid}, 32'd0);

    doFetch(32'h0000_1004, 1'b0, "R1", 1'b1);      // R1, R3, R4, R6: cold miss
    doFetch(32'h0000_101C, 1'b1, "R7", 1'b0);      // R7: last word of line hits
    doFetch(32'h0000_1000, 1'b1, "R7", 1'b0);
    doFetch(32'h0000_1007, 1'b1, "R10", 1'b0);     // R10: low bits ignored
    doFetch(32'h0000_3FFC, 1'b0, "R6", 1'b1);      // R6: requested word is last beat
    doFetch(32'h0000_3FE1, 1'b1, "R10", 1'b0);

    waitMode = 1'b1;                               // R5: stalled issue
    doFetch(32'h0002_0048, 1'b0, "R5", 1'b0);
    doFetch(32'h0002_0054, 1'b1, "R5", 1'b0);
    waitMode = 1'b0;

    doFetch(32'h0000_2010, 1'b0, "R8", 1'b1);      // R8: same index, other tag
    doFetch(32'h0000_1004, 1'b0, "R8", 1'b1);      // displaced line misses
    doFetch(32'h0000_2010, 1'b0, "R8", 1'b1);

    @(negedge clk); invAll = 1'b1;                 // R9: invalidate all
    @(negedge clk); invAll = 1'b0;
    doFetch(32'h0000_2014, 1'b0, "R9", 1'b1);
    doFetch(32'h0002_0048, 1'b0, "R9", 1'b1);
    doFetch(32'h0002_004C, 1'b1, "R9", 1'b0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule